// File: doc/BRIEF.md
# Flash controller status flag register

This block holds the 32-bit status word of a flash memory controller. It watches one-cycle event pulses from the flash sequencer: operation start (with a bank select), first data word sent, operation complete, and the individual error causes. From them it keeps three hardware-only busy indicators and a set of sticky flags. Software reads the word at any time and clears a sticky flag by writing 1 to its bit.

A level interrupt request is raised while the read-protection error flag is set and its enable input is high. The option-load validity error is taken from the option loader at the first clock edge after every reset release. If loading is still faulty, it therefore comes back after each reset. A configuration-lock output follows the configuration-busy flag. The control register uses it to block changes to its page and bank selection fields while a program operation holds them.

Top module: `flash_status_reg`

## Requirements
- R1: Bit map of `rd_data_o`: 0 end of operation, 1 operation error, 3 programming error, 4 write-protection error, 5 alignment error, 6 size error, 7 sequence error, 8 data-miss error, 9 fast-programming error, 14 read-protection error, 15 option-load error, 16 bank 1 busy, 17 bank 2 busy, 18 configuration busy. Every other bit reads 0.
- R2: While reset is asserted, and after release until the first clock edge, every bit reads 0. At that first edge, bit 15 takes the value of `opt_load_err_i`.
- R3: `op_start_i` sets bit 16 when `op_bank_i`=0 and bit 17 when `op_bank_i`=1, visible one cycle later. `op_done_i` or any operation error event (the events behind bits 1 and 3 to 8) clears both busy bits one cycle later. A clear in the same cycle wins over a start.
- R4: Bit 18 is set one cycle after `first_word_i` and not by `op_start_i`. It is cleared by completion or by an operation error, with the clear winning. `cfg_lock_o` always equals bit 18.
- R5: An `op_done_i` pulse sets bit 0 one cycle later.
- R6: Each error event input sets its own flag (R1) one cycle later, and the flag stays set until cleared by software.
- R7: When `fast_mode_i` is 1, a write-protection, alignment, size or data-miss event sets bit 9 in the same cycle as its cause bit. With `fast_mode_i`=0, or for any other event, bit 9 is not set.
- R8: A bus write with a 1 clears the corresponding sticky flag (bits 0, 1, 3 to 9, 14, 15) one cycle later. Data bits at 0 have no effect. Bits 16 to 18 ignore writes.
- R9: A hardware set and a software clear of the same flag in the same cycle leave the flag set.
- R10: `irq_o` is 1 exactly while bit 14 is set and `rderr_ie_i` is 1.
- R11: After each later reset, bit 15 is again loaded from `opt_load_err_i`. It ends up 1 if the input is 1, even if software cleared the flag before that reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| opt_load_err_i | input | 1 | Option loading result, 1 = options may be wrong |
| op_start_i | input | 1 | Operation start pulse |
| op_bank_i | input | 1 | Bank of the starting operation, 0 = bank 1, 1 = bank 2 |
| first_word_i | input | 1 | First program word sent pulse |
| op_done_i | input | 1 | Operation complete pulse |
| op_err_i | input | 1 | Operation error event |
| prog_err_i | input | 1 | Programming error event |
| wrp_err_i | input | 1 | Write-protection error event |
| align_err_i | input | 1 | Alignment error event |
| size_err_i | input | 1 | Size error event |
| seq_err_i | input | 1 | Sequence error event |
| miss_err_i | input | 1 | Data-miss error event |
| fast_mode_i | input | 1 | Fast programming sequence active |
| rd_prot_err_i | input | 1 | Read of a protected region event |
| rderr_ie_i | input | 1 | Read-protection interrupt enable |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 32 | Register write data, 1 bits clear flags |
| rd_data_o | output | 32 | Status word read-back |
| cfg_lock_o | output | 1 | Page and bank selection lock |
| irq_o | output | 1 | Read-protection interrupt request |

## Verification
Every flag and busy bit passes through exactly one register, so each result of an event or bus write is due at the first rising edge after it is applied. The interrupt and lock outputs are combinational from those registers and follow in the same cycle. The bench drives inputs on the falling edge, lets one rising edge pass, and compares the whole word, the lock and the interrupt at the next falling edge against a model advanced by one step. Bit 15 is special: it is checked once before the first edge after reset release, where it must still read 0, and once after that edge, where it must hold the sampled input.

// File: rtl/fsr_pkg.sv
package fsr_pkg;

    localparam int unsigned WORD_W = 32;

    localparam int unsigned B_EOP   = 0;
    localparam int unsigned B_OPER  = 1;
    localparam int unsigned B_PROG  = 3;
    localparam int unsigned B_WRP   = 4;
    localparam int unsigned B_ALIGN = 5;
    localparam int unsigned B_SIZE  = 6;
    localparam int unsigned B_SEQ   = 7;
    localparam int unsigned B_MISS  = 8;
    localparam int unsigned B_FAST  = 9;
    localparam int unsigned B_RDP   = 14;
    localparam int unsigned B_OPTV  = 15;
    localparam int unsigned B_BSY1  = 16;
    localparam int unsigned B_BSY2  = 17;
    localparam int unsigned B_CFG   = 18;

    // Sticky, write-1-to-clear bits
    localparam logic [WORD_W-1:0] STICKY_MASK = 32'h0000_C3FB;

    typedef struct packed {
        logic done;
        logic op_err;
        logic prog_err;
        logic wrp_err;
        logic align_err;
        logic size_err;
        logic seq_err;
        logic miss_err;
        logic rd_prot;
        logic fast;
    } fsr_events_t;

    typedef struct packed {
        logic bsy1;
        logic bsy2;
        logic cfg;
    } fsr_busy_t;

endpackage

// File: rtl/fsr_event_map.sv
module fsr_event_map
    import fsr_pkg::*;
#(
    parameter int unsigned WIDTH = WORD_W
) (
    input  fsr_events_t      ev_i,
    input  logic             opt_sample_i,
    input  logic             opt_err_i,
    output logic [WIDTH-1:0] set_o,
    output logic             abort_o
);

    logic fast_cause;

    always_comb begin
        fast_cause = ev_i.wrp_err | ev_i.align_err | ev_i.size_err | ev_i.miss_err;
        abort_o    = ev_i.op_err | ev_i.prog_err | ev_i.seq_err | fast_cause;

        set_o          = '0;
        set_o[B_EOP]   = ev_i.done;
        set_o[B_OPER]  = ev_i.op_err;
        set_o[B_PROG]  = ev_i.prog_err;
        set_o[B_WRP]   = ev_i.wrp_err;
        set_o[B_ALIGN] = ev_i.align_err;
        set_o[B_SIZE]  = ev_i.size_err;
        set_o[B_SEQ]   = ev_i.seq_err;
        set_o[B_MISS]  = ev_i.miss_err;
        set_o[B_FAST]  = ev_i.fast & fast_cause;
        set_o[B_RDP]   = ev_i.rd_prot;
        set_o[B_OPTV]  = opt_sample_i & opt_err_i;
    end

endmodule

// File: rtl/fsr_busy_track.sv
module fsr_busy_track
    import fsr_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      start_i,
    input  logic      bank_i,
    input  logic      first_word_i,
    input  logic      done_i,
    input  logic      abort_i,
    output fsr_busy_t busy_o
);

    fsr_busy_t busy_d, busy_q;
    logic      finish;

    always_comb begin
        finish      = done_i | abort_i;
        busy_d      = busy_q;
        if (start_i && !bank_i) busy_d.bsy1 = 1'b1;
        if (start_i &&  bank_i) busy_d.bsy2 = 1'b1;
        if (first_word_i)       busy_d.cfg  = 1'b1;
        if (finish) begin
            busy_d.bsy1 = 1'b0;
            busy_d.bsy2 = 1'b0;
            busy_d.cfg  = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) busy_q <= '0;
        else        busy_q <= busy_d;
    end

    assign busy_o = busy_q;

endmodule

// File: rtl/fsr_sticky_bank.sv
module fsr_sticky_bank #(
    parameter int unsigned      WIDTH = 32,
    parameter logic [WIDTH-1:0] MASK  = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] set_i,
    input  logic [WIDTH-1:0] clr_i,
    output logic [WIDTH-1:0] flags_o
);

    typedef struct packed {
        logic [WIDTH-1:0] flags;
    } sticky_t;

    sticky_t st_d, st_q;

    always_comb begin
        // set dominates over a simultaneous clear
        st_d.flags = ((st_q.flags & ~clr_i) | set_i) & MASK;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flags_o = st_q.flags;

endmodule

// File: rtl/flash_status_reg.sv
module flash_status_reg
    import fsr_pkg::*;
#(
    parameter int unsigned DATA_W = WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              opt_load_err_i,
    input  logic              op_start_i,
    input  logic              op_bank_i,
    input  logic              first_word_i,
    input  logic              op_done_i,
    input  logic              op_err_i,
    input  logic              prog_err_i,
    input  logic              wrp_err_i,
    input  logic              align_err_i,
    input  logic              size_err_i,
    input  logic              seq_err_i,
    input  logic              miss_err_i,
    input  logic              fast_mode_i,
    input  logic              rd_prot_err_i,
    input  logic              rderr_ie_i,
    input  logic              wr_en_i,
    input  logic [DATA_W-1:0] wr_data_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              cfg_lock_o,
    output logic              irq_o
);

    typedef struct packed {
        logic init_pending;
    } top_state_t;

    top_state_t        st_d, st_q;
    fsr_events_t       ev;
    logic [DATA_W-1:0] set_vec;
    logic [DATA_W-1:0] clr_vec;
    logic [DATA_W-1:0] flags;
    logic              abort;
    fsr_busy_t         busy;

    always_comb begin
        st_d.init_pending = 1'b0;
        ev.done      = op_done_i;
        ev.op_err    = op_err_i;
        ev.prog_err  = prog_err_i;
        ev.wrp_err   = wrp_err_i;
        ev.align_err = align_err_i;
        ev.size_err  = size_err_i;
        ev.seq_err   = seq_err_i;
        ev.miss_err  = miss_err_i;
        ev.rd_prot   = rd_prot_err_i;
        ev.fast      = fast_mode_i;
        clr_vec      = wr_en_i ? wr_data_i : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{init_pending: 1'b1};
        else        st_q <= st_d;
    end

    fsr_event_map #(.WIDTH(DATA_W)) i_map (
        .ev_i         (ev),
        .opt_sample_i (st_q.init_pending),
        .opt_err_i    (opt_load_err_i),
        .set_o        (set_vec),
        .abort_o      (abort)
    );

    fsr_sticky_bank #(.WIDTH(DATA_W), .MASK(DATA_W'(STICKY_MASK))) i_sticky (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_i   (set_vec),
        .clr_i   (clr_vec),
        .flags_o (flags)
    );

    fsr_busy_track i_busy (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (op_start_i),
        .bank_i       (op_bank_i),
        .first_word_i (first_word_i),
        .done_i       (op_done_i),
        .abort_i      (abort),
        .busy_o       (busy)
    );

    always_comb begin
        rd_data_o         = flags;
        rd_data_o[B_BSY1] = busy.bsy1;
        rd_data_o[B_BSY2] = busy.bsy2;
        rd_data_o[B_CFG]  = busy.cfg;
        cfg_lock_o        = busy.cfg;
        irq_o             = flags[B_RDP] & rderr_ie_i;
    end

endmodule

// File: rtl/fsr_checker.sv
module fsr_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        op_start_i,
    input logic        first_word_i,
    input logic        op_done_i,
    input logic        op_err_i,
    input logic        prog_err_i,
    input logic        wrp_err_i,
    input logic        align_err_i,
    input logic        size_err_i,
    input logic        seq_err_i,
    input logic        miss_err_i,
    input logic        rderr_ie_i,
    input logic        wr_en_i,
    input logic [31:0] wr_data_i,
    input logic [31:0] rd_data_o,
    input logic        cfg_lock_o,
    input logic        irq_o
);

    logic abort;
    assign abort = op_err_i | prog_err_i | wrp_err_i | align_err_i |
                   size_err_i | seq_err_i | miss_err_i;

    a_r1_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data_o & 32'hFFF8_3C04) == 32'h0);

    a_r3_busy_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        (op_done_i || abort) |=> rd_data_o[17:16] == 2'b00 && !cfg_lock_o);

    a_r4_lock_follows_first_word: assert property (@(posedge clk) disable iff (!rst_n)
        (first_word_i && !op_done_i && !abort) |=> cfg_lock_o);

    a_r7_fast_with_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_data_o[9]) |-> (rd_data_o[4] || rd_data_o[5] || rd_data_o[6] || rd_data_o[8]));

    a_r8_busy_no_sw_set: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && !op_start_i && !first_word_i) |=>
        (rd_data_o[18:16] & ~$past(rd_data_o[18:16])) == 3'b000);

    a_r9_set_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (op_done_i && wr_en_i && wr_data_i[0]) |=> rd_data_o[0]);

    a_r10_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (rderr_ie_i && rd_data_o[14]));

endmodule

bind flash_status_reg fsr_checker i_fsr_checker (.*);

// File: tb/test_flash_status_reg.sv
module test_flash_status_reg;

    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        opt_load_err_i = 1'b0;
    logic        op_start_i = 1'b0, op_bank_i = 1'b0, first_word_i = 1'b0, op_done_i = 1'b0;
    logic        op_err_i = 1'b0, prog_err_i = 1'b0, wrp_err_i = 1'b0, align_err_i = 1'b0;
    logic        size_err_i = 1'b0, seq_err_i = 1'b0, miss_err_i = 1'b0, fast_mode_i = 1'b0;
    logic        rd_prot_err_i = 1'b0, rderr_ie_i = 1'b0, wr_en_i = 1'b0;
    logic [31:0] wr_data_i = '0;
    logic [31:0] rd_data_o;
    logic        cfg_lock_o, irq_o;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 0;

    // model state
    logic [31:0] m_flags = '0;
    logic        m_b1 = 0, m_b2 = 0, m_cfg = 0, m_init = 1;

    always #(CLK_PERIOD/2) clk = ~clk;

    flash_status_reg i_flash_status_reg (.*);

    // event index -> flag bit (bench-side map from R1)
    function automatic int ev_bit(int k);
        case (k)
            0: return 0;  1: return 1;  2: return 3;  3: return 4;  4: return 5;
            5: return 6;  6: return 7;  7: return 8;  default: return 14;
        endcase
    endfunction

    task automatic drive_ev(int k, logic v);
        case (k)
            0: op_done_i = v;   1: op_err_i = v;    2: prog_err_i = v;
            3: wrp_err_i = v;   4: align_err_i = v; 5: size_err_i = v;
            6: seq_err_i = v;   7: miss_err_i = v;  default: rd_prot_err_i = v;
        endcase
    endtask

    task automatic clear_inputs();
        op_start_i = 0; first_word_i = 0;
        for (int k = 0; k < 9; k++) drive_ev(k, 1'b0);
        wr_en_i = 0; wr_data_i = '0;
    endtask

    function automatic logic [31:0] exp_word();
        return m_flags | {13'b0, m_cfg, m_b2, m_b1, 16'b0};
    endfunction

    task automatic check(string tag);
        logic [31:0] e;
        logic        ei;
        e  = exp_word();
        ei = m_flags[14] & rderr_ie_i;
        n_checks++;
        if (rd_data_o !== e || cfg_lock_o !== m_cfg || irq_o !== ei) begin
            n_fail++;
            $display("FAIL %s: word=%h lock=%b irq=%b expected word=%h lock=%b irq=%b",
                     tag, rd_data_o, cfg_lock_o, irq_o, e, m_cfg, ei);
        end
    endtask

    // one clock: inputs already driven; advance model; check at falling edge
    task automatic tick(string tag);
        logic        abort, fc;
        logic [31:0] setv, clrv;
        @(posedge clk);
        fc    = wrp_err_i | align_err_i | size_err_i | miss_err_i;
        abort = op_err_i | prog_err_i | seq_err_i | fc;
        setv  = '0;
        setv[0] = op_done_i;  setv[1] = op_err_i;    setv[3] = prog_err_i;
        setv[4] = wrp_err_i;  setv[5] = align_err_i; setv[6] = size_err_i;
        setv[7] = seq_err_i;  setv[8] = miss_err_i;  setv[9] = fast_mode_i & fc;
        setv[14] = rd_prot_err_i;
        setv[15] = m_init & opt_load_err_i;
        clrv = wr_en_i ? (wr_data_i & 32'h0000_C3FB) : '0;
        m_flags = (m_flags & ~clrv) | setv;
        m_b1  = (m_b1 | (op_start_i & ~op_bank_i)) & ~(op_done_i | abort);
        m_b2  = (m_b2 | (op_start_i & op_bank_i)) & ~(op_done_i | abort);
        m_cfg = (m_cfg | first_word_i) & ~(op_done_i | abort);
        m_init = 0;
        @(negedge clk);
        clear_inputs();
        check(tag);
    endtask

    task automatic do_reset(logic opt);
        @(negedge clk);
        rst_n = 0; opt_load_err_i = opt;
        clear_inputs();
        m_flags = '0; m_b1 = 0; m_b2 = 0; m_cfg = 0; m_init = 1;
        repeat (2) @(negedge clk);
        check("R2 during reset");
        rst_n = 1;
        #1;
        check("R2 before first edge");
        tick("R2 opt sampled");
        opt_load_err_i = 0;
    endtask

    task automatic wr(logic [31:0] d);
        wr_en_i = 1; wr_data_i = d;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            n_fail++; n_checks++;
            $display("FAIL watchdog: expired, expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        do_reset(1'b0);

        // R5 R6 R7 R8: every event, both fast modes
        for (int fm = 0; fm < 2; fm++) begin
            for (int k = 0; k < 9; k++) begin
                fast_mode_i = fm[0];
                drive_ev(k, 1'b1);
                tick("R6 R5 R7 event sets flag");
                wr(~(32'h1 << ev_bit(k)) & 32'h0000_FFFF);
                wr_data_i[ev_bit(k)] = 1'b0;
                if (fm == 1) wr_data_i[9] = 1'b0;
                tick("R8 write 0 no effect");
                wr(32'h1 << ev_bit(k));
                tick("R8 write 1 clears");
                wr(32'h0000_0200);
                tick("R8 clear fast flag");
            end
        end
        fast_mode_i = 0;

        // R3 R4: each bank, each terminator
        for (int b = 0; b < 2; b++) begin
            for (int t = 0; t < 8; t++) begin
                op_start_i = 1; op_bank_i = b[0];
                tick("R3 start sets bank busy");
                check("R4 start leaves lock low");
                first_word_i = 1;
                tick("R4 first word sets lock");
                wr(32'hFFFF_FFFF);
                tick("R8 busy ignores writes");
                drive_ev(t, 1'b1);
                tick("R3 R4 terminator clears busy");
                wr(32'h0000_FFFF);
                tick("R8 clear all");
            end
        end

        // R3 clear wins over start in same cycle
        op_start_i = 1; op_done_i = 1;
        tick("R3 done beats start");
        op_start_i = 1; op_bank_i = 1; prog_err_i = 1;
        tick("R3 error beats start");
        wr(32'h0000_FFFF); tick("R8 clear all");

        // R9 set wins, every event
        for (int k = 0; k < 9; k++) begin
            tick("R9 prime");
            drive_ev(k, 1'b1);
            wr(32'hFFFF_FFFF);
            tick("R9 set beats clear");
            wr(32'hFFFF_FFFF);
            tick("R9 then cleared");
        end

        // R10 irq
        for (int ie = 0; ie < 2; ie++) begin
            rderr_ie_i = ie[0];
            #1; check("R10 irq idle");
            rd_prot_err_i = 1;
            tick("R10 irq level");
            tick("R10 irq held");
            rderr_ie_i = ~ie[0];
            #1; check("R10 enable toggled");
            rderr_ie_i = ie[0];
            wr(32'h0000_4000);
            tick("R10 irq cleared");
        end
        rderr_ie_i = 0;

        // R2 R11 option-load flag across resets
        do_reset(1'b1);
        wr(32'h0000_8000);
        tick("R8 opt flag cleared");
        do_reset(1'b1);
        check("R11 opt reasserted");
        do_reset(1'b0);
        check("R11 opt stays low");
        do_reset(1'b1);
        tick("R11 opt sticky");

        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule